// File: doc/BRIEF.md
# Framed Test-Pattern Generator

This block produces an endless sequence of fixed-layout test frames on a 32-bit word stream. Every word is qualified by a valid signal and is consumed when the downstream stage raises ready. It is placed at the sending end of a point-to-point data link so that the far end can check each received word against a pattern it can predict.

A frame opens with a start control word and closes with an end control word, and a side flag marks those two words. Between them come a nine-word header, an incrementing payload and a three-word footer. The header carries a running frame number and a value derived from it. The footer carries the payload word count. The frame length is set by a configuration input, is clamped to a legal range, and is picked up only when a new frame begins.

Top module: `fpg_top`

## Requirements
- R1: While `rst_n` is low, `gen_valid` is 0. After reset is released, the first word presented is the start control word of frame number 1, and its length is taken from `cfg_len` as it stands at the first clock edge after the release.
- R2: `gen_ctrl` is 1 only on word 0 of a frame, which carries `SOF_WORD` (default 0xB0F00000), and on word L-1, which carries `EOF_WORD` (default 0xE0F00000). Here L is the frame length. `gen_ctrl` is 0 on every other word.
- R3: Words 1 to 9 form the header. Header slot k sits at word 1+k. Slot 2 holds the frame number N. Slot 5 holds (3N-2) mod 4096, zero-extended. Each other slot k holds `HDR_BASE`+k (default base 0xA0A00000).
- R4: Words 10 to L-5 form the payload and carry the values 0, 1, ..., L-15 in order.
- R5: Words L-4 to L-2 form the footer. Slot 0 holds `FTR_BASE`, slot 1 holds L-14, and slot 2 holds `FTR_BASE`+2 (default base 0xF0F00000).
- R6: The frame length L equals `cfg_len` when the value lies in 16..1024. A smaller value gives 16, and a larger value gives 1024.
- R7: `cfg_len` is sampled only when a frame begins: at the edge that accepts the previous end word, or at the first edge after reset. A change made in the middle of a frame leaves that frame unchanged.
- R8: The frame number starts at 1 and increases by exactly one for each completed frame.
- R9: While `gen_valid` is 1 and `gen_ready` is 0, the word and the flag hold steady and `gen_valid` stays 1.
- R10: Frames follow one another with no gap. The word after an accepted end word is the start word of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 11 | Requested frame length in words |
| gen_data | output | 32 | Current output word |
| gen_ctrl | output | 1 | High on the start and end control words |
| gen_valid | output | 1 | Output word is valid |
| gen_ready | input | 1 | Downstream accepts the word at this edge |

## Verification
The presented word is decoded combinationally from registered position state. A word that is shown while ready is high is taken at the next rising edge, and its successor is visible right after that edge. The first word appears one edge after reset is released. The bench samples valid, ready and the word at the falling edge, and it pops one expected item for each word that will be taken at the coming edge. A stalled word is compared with the value seen one falling edge earlier. `cfg_len` is changed in the middle of a frame, so the new value applies to the following frame, which is the frame the driver queues next.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [2:0] {
    SEG_SOF,
    SEG_HDR,
    SEG_PAY,
    SEG_FTR,
    SEG_EOF
  } seg_e;

  localparam int HDR_LEN = 9;
  localparam int FTR_LEN = 3;
  localparam int OVERHEAD = 2 + HDR_LEN + FTR_LEN;
endpackage

// File: rtl/fpg_frame_seq.sv
module fpg_frame_seq #(
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             prime,
  input  logic             adv,
  output logic [LEN_W-1:0] idx,
  output logic [LEN_W-1:0] len_q,
  output logic [CNT_W-1:0] frame_n,
  output logic             last
);
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] idx_d, len_d, len_clamped;
  logic [CNT_W-1:0] frame_d;

  always_comb begin
    if (cfg_len < LMIN)      len_clamped = LMIN;
    else if (cfg_len > LMAX) len_clamped = LMAX;
    else                     len_clamped = cfg_len;
  end

  assign last = (idx == len_q - LEN_W'(1));

  always_comb begin
    idx_d   = idx;
    len_d   = len_q;
    frame_d = frame_n;
    if (prime) begin
      len_d = len_clamped;
    end else if (adv) begin
      if (last) begin
        idx_d   = '0;
        len_d   = len_clamped;
        frame_d = frame_n + CNT_W'(1);
      end else begin
        idx_d = idx + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      len_q   <= LMIN;
      frame_n <= CNT_W'(1);
    end else if (prime || adv) begin
      idx     <= idx_d;
      len_q   <= len_d;
      frame_n <= frame_d;
    end
  end

  // R6: the latched length always lies in the legal range
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LMIN) && (len_q <= LMAX));

  // R7: the length moves only at a frame boundary
  a_r7_len_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_q) |-> $past(prime || (adv && last)));

  // R8: the frame number steps by one after a completed frame
  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_n) |-> (frame_n == $past(frame_n) + CNT_W'(1)) && $past(adv && last));
endmodule

// File: rtl/fpg_word_gen.sv
module fpg_word_gen
  import fpg_pkg::*;
#(
  parameter int          LEN_W    = 11,
  parameter int          CNT_W    = 32,
  parameter int          DATA_W   = 32,
  parameter int          MOD_W    = 12,
  parameter int          SEQ_SLOT = 2,
  parameter int          MOD_SLOT = 5,
  parameter logic [31:0] SOF_WORD = 32'hB0F0_0000,
  parameter logic [31:0] EOF_WORD = 32'hE0F0_0000,
  parameter logic [31:0] HDR_BASE = 32'hA0A0_0000,
  parameter logic [31:0] FTR_BASE = 32'hF0F0_0000
) (
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [CNT_W-1:0]  frame_n,
  output logic [DATA_W-1:0] word,
  output logic              ctrl
);
  localparam int PAY_OFF = 1 + HDR_LEN;
  localparam int TAIL    = FTR_LEN + 1;

  seg_e             seg;
  logic [LEN_W-1:0] ftr_start, hdr_slot, ftr_slot, pay_val, pay_cnt;
  logic [MOD_W-1:0] seq_lo, mod_v;

  assign ftr_start = len_q - LEN_W'(TAIL);
  assign hdr_slot  = idx - LEN_W'(1);
  assign ftr_slot  = idx - ftr_start;
  assign pay_val   = idx - LEN_W'(PAY_OFF);
  assign pay_cnt   = len_q - LEN_W'(OVERHEAD);
  assign seq_lo    = frame_n[MOD_W-1:0];
  assign mod_v     = (seq_lo << 1) + seq_lo - MOD_W'(2);

  always_comb begin
    if (idx == '0)                       seg = SEG_SOF;
    else if (idx <= LEN_W'(HDR_LEN))     seg = SEG_HDR;
    else if (idx < ftr_start)            seg = SEG_PAY;
    else if (idx < len_q - LEN_W'(1))    seg = SEG_FTR;
    else                                 seg = SEG_EOF;
  end

  always_comb begin
    ctrl = 1'b0;
    word = '0;
    unique case (seg)
      SEG_SOF: begin
        ctrl = 1'b1;
        word = DATA_W'(SOF_WORD);
      end
      SEG_HDR: begin
        if (hdr_slot == LEN_W'(SEQ_SLOT))      word = DATA_W'(frame_n);
        else if (hdr_slot == LEN_W'(MOD_SLOT)) word = DATA_W'(mod_v);
        else                                   word = DATA_W'(HDR_BASE) + DATA_W'(hdr_slot);
      end
      SEG_PAY: word = DATA_W'(pay_val);
      SEG_FTR: begin
        if (ftr_slot == LEN_W'(1)) word = DATA_W'(pay_cnt);
        else                       word = DATA_W'(FTR_BASE) + DATA_W'(ftr_slot);
      end
      SEG_EOF: begin
        ctrl = 1'b1;
        word = DATA_W'(EOF_WORD);
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/fpg_top.sv
module fpg_top #(
  parameter int          MIN_LEN  = 16,
  parameter int          MAX_LEN  = 1024,
  parameter int          CNT_W    = 32,
  parameter int          DATA_W   = 32,
  parameter int          MOD_W    = 12,
  parameter int          SEQ_SLOT = 2,
  parameter int          MOD_SLOT = 5,
  parameter logic [31:0] SOF_WORD = 32'hB0F0_0000,
  parameter logic [31:0] EOF_WORD = 32'hE0F0_0000,
  parameter logic [31:0] HDR_BASE = 32'hA0A0_0000,
  parameter logic [31:0] FTR_BASE = 32'hF0F0_0000,
  localparam int         LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic [DATA_W-1:0] gen_data,
  output logic              gen_ctrl,
  output logic              gen_valid,
  input  logic              gen_ready
);
  logic             valid_q, prime, adv, last;
  logic [LEN_W-1:0] idx, len_q;
  logic [CNT_W-1:0] frame_n;

  assign prime     = !valid_q;
  assign adv       = valid_q && gen_ready;
  assign gen_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  fpg_frame_seq #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .prime(prime), .adv(adv),
    .idx(idx), .len_q(len_q), .frame_n(frame_n), .last(last)
  );

  fpg_word_gen #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .MOD_W(MOD_W),
    .SEQ_SLOT(SEQ_SLOT), .MOD_SLOT(MOD_SLOT), .SOF_WORD(SOF_WORD),
    .EOF_WORD(EOF_WORD), .HDR_BASE(HDR_BASE), .FTR_BASE(FTR_BASE)
  ) word_i (
    .idx(idx), .len_q(len_q), .frame_n(frame_n), .word(gen_data), .ctrl(gen_ctrl)
  );

  // R1: valid is low while reset is held
  always_comb begin
    if (!rst_n) a_r1_no_valid_in_reset: assert (!gen_valid);
  end

  // R9: a stalled word stays put
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && !gen_ready |=> gen_valid && $stable(gen_data) && $stable(gen_ctrl));

  // R2: the flag appears only at the frame ends
  a_r2_ctrl_at_ends: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && gen_ctrl |-> (idx == '0) || last);

  // R10: an accepted end word is followed at once by a start word
  a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && gen_ready && last |=> gen_valid && gen_ctrl && (gen_data == DATA_W'(SOF_WORD)));
endmodule

// File: tb/fpg_top_tb_top.sv
module fpg_top_tb_top;
  localparam logic [31:0] SOFW = 32'hB0F0_0000;
  localparam logic [31:0] EOFW = 32'hE0F0_0000;
  localparam logic [31:0] HB   = 32'hA0A0_0000;
  localparam logic [31:0] FB   = 32'hF0F0_0000;
  localparam int NFR = 8;

  typedef struct {
    logic [31:0] d;
    logic        c;
    string       r;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] cfg_len;
  logic [31:0] gen_data;
  logic        gen_ctrl, gen_valid;
  logic        gen_ready;

  int    checks = 0;
  int    errors = 0;
  int    popped = 0;
  bit    done   = 0;
  item_t expq[$];

  always #2.5 clk = ~clk;

  fpg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .gen_data(gen_data),
    .gen_ctrl(gen_ctrl), .gen_valid(gen_valid), .gen_ready(gen_ready)
  );

  function automatic int clampl(input int v);
    if (v < 16)   return 16;
    if (v > 1024) return 1024;
    return v;
  endfunction

  task automatic push(input logic [31:0] d, input logic c, input string r);
    item_t it;
    it.d = d; it.c = c; it.r = r;
    expq.push_back(it);
  endtask

  task automatic push_frame(input int req, input int n, input string sof_tag, input string len_tag);
    int L;
    logic [11:0] m;
    L = clampl(req);
    m = 12'(3 * n - 2);
    push(SOFW, 1'b1, sof_tag);
    for (int k = 0; k < 9; k++) begin
      if (k == 2)      push(32'(n), 1'b0, "R8");
      else if (k == 5) push({20'd0, m}, 1'b0, "R3");
      else             push(HB + 32'(k), 1'b0, "R3");
    end
    for (int p = 0; p <= L - 15; p++) push(32'(p), 1'b0, "R4");
    push(FB, 1'b0, "R5");
    push(32'(L - 14), 1'b0, len_tag);
    push(FB + 32'd2, 1'b0, "R5");
    push(EOFW, 1'b1, "R2");
  endtask

  // ready pattern with frequent stalls
  logic [15:0] lfsr = 16'hACE1;
  initial begin
    gen_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gen_ready = (lfsr[1:0] != 2'b00) && (lfsr[6:4] != 3'b000);
    end
  end

  // monitor: scoreboard pop and stall hold checks
  logic        prev_stall = 1'b0;
  logic [31:0] prev_d;
  logic        prev_c;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (prev_stall) begin
          checks++;
          if (!gen_valid || gen_data !== prev_d || gen_ctrl !== prev_c) begin
            errors++;
            $display("FAIL R9 stall hold: got v=%0b d=%h c=%0b exp v=1 d=%h c=%0b",
                     gen_valid, gen_data, gen_ctrl, prev_d, prev_c);
          end
        end
        if (gen_valid && gen_ready && expq.size() > 0) begin
          item_t e;
          e = expq.pop_front();
          popped++;
          checks++;
          if (gen_data !== e.d || gen_ctrl !== e.c) begin
            errors++;
            $display("FAIL %s word %0d: got d=%h c=%0b exp d=%h c=%0b",
                     e.r, popped, gen_data, gen_ctrl, e.d, e.c);
          end
        end
        prev_stall = gen_valid && !gen_ready;
        prev_d     = gen_data;
        prev_c     = gen_ctrl;
      end
    end
  end

  // driver
  int lens[NFR] = '{20, 16, 5, 1500, 17, 40, 1024, 33};
  initial begin
    int start;
    rst_n   = 1'b0;
    cfg_len = 11'(lens[0]);
    repeat (4) @(negedge clk);
    checks++;
    if (gen_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid in reset: got %0b exp 0", gen_valid);
    end
    push_frame(lens[0], 1, "R1", "R5");
    rst_n = 1'b1;
    start = 0;
    for (int k = 0; k < NFR; k++) begin
      while (popped < start + 3) @(posedge clk);
      #1;
      start = start + clampl(lens[k]);
      if (k + 1 < NFR) begin
        cfg_len = 11'(lens[k + 1]);
        // frame k keeps its length (R7); the next one takes the new value (R6)
        push_frame(lens[k + 1], k + 2, "R10",
                   (lens[k + 1] < 16 || lens[k + 1] > 1024) ? "R6" : "R7");
      end
    end
    while (expq.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d words left exp 0", expq.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule